// File: doc/BRIEF.md
# Root Hub Port Status and Control Registers

This block holds the 16-bit status/control word of each downstream port of a full-speed USB root hub. The host reads and writes the words through a small byte-addressed register window. A port model reports device attach and detach events and the speed of the attached device. The block keeps each port's connect, enable, change and low-speed flags up to date. When the host starts a port reset it sends a single-cycle bus-reset request to that port's device.

A host write does not simply replace the word. A fixed mask marks the bits the hardware owns, and those keep their value. The host-owned bits take the written value. The two change flags are cleared by writing a one to them. Attach and detach events are applied after any host write in the same cycle. Slots in the window that have no port behind them read back a fixed pattern and ignore writes.

Top module: `rh_port_regs`

## Requirements
- R1: After reset every port word reads 0x0000 and `busResetReq` is all zero. The word's fields are: bit 0 connected, bit 1 connect changed, bit 2 enabled, bit 3 enable changed, bit 8 low-speed device, bit 9 port reset.
- R2: On a host write, the bits set in mask 0x01FB keep their previous value. Every other bit (2, 9 and 10 to 15) takes the written value. Bits 4 to 7 therefore stay 0.
- R3: After the merge of R2, writing a 1 to bit 1 or to bit 3 clears that bit. Writing a 0 to either leaves it unchanged.
- R4: A write with bit 9 set, to a port whose bit 9 was 0 and whose bit 0 was 1, raises that port's `busResetReq` bit for exactly one cycle, in the cycle after the write. Writing bit 9 while it is already 1, or while the port is not connected, gives no pulse.
- R5: An attach event sets bits 0 and 1 and copies `devLowSpeed` into bit 8. If the port was already connected and enabled, the attach also clears bit 2 and sets bit 3.
- R6: A detach event on a connected port clears bit 0 and sets bit 1. On an enabled port it clears bit 2 and sets bit 3. A detach on a port that is neither connected nor enabled changes nothing.
- R7: Port i lives at byte offset 0x10 + 2*i. Writes to addresses outside 0x10–0x1F, or to odd addresses, have no effect. Reads of such addresses return 0x0000.
- R8: An even address in the window whose slot index is at least NUM_PORTS reads 0xFF7F. A write to it changes no port.
- R9: When an event and a host write hit the same port in the same cycle, the event is applied to the result of the write. When attach and detach arrive together, the attach wins.
- R10: Writes, events and reset pulses of one port never change another port's word or pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe, one cycle per write |
| regAddr | input | 5 | Host byte address |
| regWrData | input | 16 | Host write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| devAttach | input | NUM_PORTS | Per-port attach event, one cycle |
| devDetach | input | NUM_PORTS | Per-port detach event, one cycle |
| devLowSpeed | input | NUM_PORTS | Speed of the attaching device, 1 = low speed |
| busResetReq | output | NUM_PORTS | Per-port bus-reset request pulse |

## Verification
The functions that can meet in one cycle are a host write and a port event on the same port. The bench drives a write that clears the connect-changed flag in the same cycle as an attach. It then reads the word back and expects the flag to survive, because the event is applied last. It also drives attach and detach together and expects the attach outcome. Because each port has its own pulse register, a reset write on one port is judged against a silent `busResetReq` on the other.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

  localparam int DATA_W   = 16;
  localparam int SLOT_CNT = 8;
  localparam int SLOT_W   = $clog2(SLOT_CNT);

  localparam logic [DATA_W-1:0] KEEP_MASK   = 16'h01FB;
  localparam logic [DATA_W-1:0] W1C_MASK    = 16'h000A;
  localparam logic [DATA_W-1:0] ABSENT_WORD = 16'hFF7F;

  localparam int B_CONN     = 0;
  localparam int B_CONN_CHG = 1;
  localparam int B_EN       = 2;
  localparam int B_EN_CHG   = 3;
  localparam int B_LS       = 8;
  localparam int B_RST      = 9;

  // strobes from the decode control to the register datapath
  typedef struct packed {
    logic              hit;
    logic              absent;
    logic              wrStrobe;
    logic [SLOT_W-1:0] slot;
  } strobe_t;

  function automatic logic [DATA_W-1:0] mergeWrite(input logic [DATA_W-1:0] oldWord,
                                                   input logic [DATA_W-1:0] newWord);
    logic [DATA_W-1:0] m;
    m = (oldWord & KEEP_MASK) | (newWord & ~KEEP_MASK);
    m = m & ~(newWord & W1C_MASK);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] applyEvent(input logic [DATA_W-1:0] cur,
                                                   input logic attach,
                                                   input logic detach,
                                                   input logic lowSpeed);
    logic [DATA_W-1:0] r;
    r = cur;
    if (attach) begin
      if (r[B_CONN] && r[B_EN]) begin
        r[B_EN]     = 1'b0;
        r[B_EN_CHG] = 1'b1;
      end
      r[B_CONN]     = 1'b1;
      r[B_CONN_CHG] = 1'b1;
      r[B_LS]       = lowSpeed;
    end else if (detach) begin
      if (r[B_CONN]) begin
        r[B_CONN]     = 1'b0;
        r[B_CONN_CHG] = 1'b1;
      end
      if (r[B_EN]) begin
        r[B_EN]     = 1'b0;
        r[B_EN_CHG] = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
  import rh_port_pkg::*;
#(
  parameter int                NUM_PORTS = 2,
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 5'h10
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb
);

  localparam int HI_LSB = SLOT_W + 1;

  logic              inWindow;
  logic [SLOT_W-1:0] slot;
  logic              slotAbsent;

  assign slot       = regAddr[SLOT_W:1];
  assign inWindow   = (regAddr[ADDR_W-1:HI_LSB] == WIN_BASE[ADDR_W-1:HI_LSB]) && !regAddr[0];
  assign slotAbsent = ({1'b0, slot} >= (SLOT_W+1)'(NUM_PORTS));

  always_comb begin
    strb          = '0;
    strb.slot     = slot;
    strb.hit      = inWindow;
    strb.absent   = inWindow && slotAbsent;
    strb.wrStrobe = regWrEn && inWindow && !slotAbsent;
  end

endmodule

// File: rtl/rh_port_dp.sv
module rh_port_dp
  import rh_port_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_PORTS-1:0] devAttach,
  input  logic [NUM_PORTS-1:0] devDetach,
  input  logic [NUM_PORTS-1:0] devLowSpeed,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_PORTS-1:0] busResetReq
);

  logic [NUM_PORTS-1:0][DATA_W-1:0] portReg;
  logic [NUM_PORTS-1:0][DATA_W-1:0] portNext;
  logic [NUM_PORTS-1:0]             portWr;
  logic [NUM_PORTS-1:0]             pulseNext;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic [DATA_W-1:0] afterWr;
      portWr[p]    = strb.wrStrobe && (strb.slot == SLOT_W'(p));
      afterWr      = portWr[p] ? mergeWrite(portReg[p], wrData) : portReg[p];
      portNext[p]  = applyEvent(afterWr, devAttach[p], devDetach[p], devLowSpeed[p]);
      pulseNext[p] = portWr[p] && wrData[B_RST] && !portReg[p][B_RST] && portReg[p][B_CONN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portReg     <= '0;
      busResetReq <= '0;
    end else begin
      portReg     <= portNext;
      busResetReq <= pulseNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (strb.absent) begin
      rdData = ABSENT_WORD;
    end else if (strb.hit) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strb.slot == SLOT_W'(p)) rdData = portReg[p];
      end
    end
  end

  // R7: a host write reaches at most one port
  p_single_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portWr));

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    // R4: reset request never lasts two cycles
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rstN)
      busResetReq[g] |=> !busResetReq[g]);
    // R4: a pulse always follows a write carrying the reset bit
    p_pulse_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
      pulseNext[g] |=> (busResetReq[g] && $past(wrData[B_RST])));
    // R5: attach leaves the port connected with its change flag and speed
    p_attach_r5: assert property (@(posedge clk) disable iff (!rstN)
      devAttach[g] |=> (portReg[g][B_CONN] && portReg[g][B_CONN_CHG] &&
                        portReg[g][B_LS] == $past(devLowSpeed[g])));
    // R6: detach leaves the port disconnected and disabled
    p_detach_r6: assert property (@(posedge clk) disable iff (!rstN)
      (devDetach[g] && !devAttach[g]) |=> (!portReg[g][B_CONN] && !portReg[g][B_EN]));
    // R2: hardware-owned bits survive a host write
    p_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
      (portWr[g] && !devAttach[g] && !devDetach[g]) |=>
        ($stable(portReg[g][B_CONN]) && $stable(portReg[g][B_LS])));
    // R3: writing one to the connect-change flag clears it
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rstN)
      (portWr[g] && wrData[B_CONN_CHG] && !devAttach[g] && !devDetach[g]) |=>
        !portReg[g][B_CONN_CHG]);
    // R8: an access to an absent slot leaves the port untouched
    p_absent_r8: assert property (@(posedge clk) disable iff (!rstN)
      (strb.absent && !devAttach[g] && !devDetach[g]) |=> $stable(portReg[g]));
  end

endmodule

// File: rtl/rh_port_regs.sv
module rh_port_regs
  import rh_port_pkg::*;
#(
  parameter int                NUM_PORTS = 2,
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 5'h10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_PORTS-1:0] devAttach,
  input  logic [NUM_PORTS-1:0] devDetach,
  input  logic [NUM_PORTS-1:0] devLowSpeed,
  output logic [NUM_PORTS-1:0] busResetReq
);

  strobe_t strb;

  rh_port_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE)
  ) u_ctrl (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strb   (strb)
  );

  rh_port_dp #(
    .NUM_PORTS(NUM_PORTS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData),
    .devAttach  (devAttach),
    .devDetach  (devDetach),
    .devLowSpeed(devLowSpeed),
    .rdData     (regRdData),
    .busResetReq(busResetReq)
  );

endmodule

// File: tb/rh_port_regs_tb.sv
module rh_port_regs_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [4:0]  regAddr;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic [1:0]  devAttach;
  logic [1:0]  devDetach;
  logic [1:0]  devLowSpeed;
  logic [1:0]  busResetReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rh_port_regs u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .devAttach(devAttach),
    .devDetach(devDetach), .devLowSpeed(devLowSpeed), .busResetReq(busResetReq)
  );

  // {write data, expected word afterwards, expected pulse on port 0}
  localparam logic [32:0] VEC [0:6] = '{
    {16'h0004, 16'h0107, 1'b0},
    {16'h0002, 16'h0101, 1'b0},
    {16'h0206, 16'h0305, 1'b1},
    {16'h0206, 16'h0305, 1'b0},
    {16'hFC00, 16'hFD01, 1'b0},
    {16'h00F0, 16'h0101, 1'b0},
    {16'h0200, 16'h0301, 1'b1}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readCheck(input string tag, input logic [4:0] a, input logic [15:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  // one cycle of stimulus; returns at the following negedge
  task automatic drive(input logic wr, input logic [4:0] a, input logic [15:0] d,
                       input logic [1:0] att, input logic [1:0] det, input logic [1:0] ls);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d;
    devAttach = att; devDetach = det; devLowSpeed = ls;
    @(negedge clk);
    regWrEn = 1'b0; devAttach = 2'b00; devDetach = 2'b00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] m1;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 5'h10; regWrData = '0;
    devAttach = '0; devDetach = '0; devLowSpeed = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readCheck("R1 port0 reset", 5'h10, 16'h0000);
    readCheck("R1 port1 reset", 5'h12, 16'h0000);
    check("R1 pulse reset", {14'd0, busResetReq}, 16'h0000);

    // R5 attach port0 low speed, port1 full speed
    drive(1'b0, 5'h10, 16'h0, 2'b01, 2'b00, 2'b01);
    readCheck("R5 attach low", 5'h10, 16'h0103);
    drive(1'b0, 5'h12, 16'h0, 2'b10, 2'b00, 2'b00);
    readCheck("R5 attach full", 5'h12, 16'h0003);
    readCheck("R10 port0 after port1 attach", 5'h10, 16'h0103);

    // R2 R3 R4 vector table on port0
    for (int i = 0; i < 7; i++) begin
      drive(1'b1, 5'h10, VEC[i][32:17], 2'b00, 2'b00, 2'b00);
      check("R4 table pulse", {14'd0, busResetReq}, {15'd0, VEC[i][0]});
      readCheck("R2/R3 table word", 5'h10, VEC[i][16:1]);
      @(negedge clk);
      check("R4 table pulse drop", {14'd0, busResetReq}, 16'h0000);
    end

    // R2 R3 R4 random writes on port1 against the requirement formula
    m1 = 16'h0003;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] w;
      logic expP;
      w = 16'($urandom);
      expP = w[9] && !m1[9] && m1[0];
      m1 = (m1 & 16'h01FB) | (w & ~16'h01FB);
      m1 = m1 & ~(w & 16'h000A);
      drive(1'b1, 5'h12, w, 2'b00, 2'b00, 2'b00);
      check("R4 random pulse", {14'd0, busResetReq}, {14'd0, expP, 1'b0});
      readCheck("R2 random word", 5'h12, m1);
    end

    // R7 R8 decode
    readCheck("R8 absent slot2", 5'h14, 16'hFF7F);
    readCheck("R8 absent slot7", 5'h1E, 16'hFF7F);
    readCheck("R7 outside window", 5'h00, 16'h0000);
    readCheck("R7 odd address", 5'h11, 16'h0000);
    drive(1'b1, 5'h14, 16'hFFFF, 2'b00, 2'b00, 2'b00);
    drive(1'b1, 5'h00, 16'hFFFF, 2'b00, 2'b00, 2'b00);
    drive(1'b1, 5'h11, 16'hFFFF, 2'b00, 2'b00, 2'b00);
    readCheck("R8 absent write port0", 5'h10, 16'h0301);
    readCheck("R7 stray write port1", 5'h12, m1);

    // R6 detach while connected and enabled
    drive(1'b1, 5'h10, 16'h0004, 2'b00, 2'b00, 2'b00);
    readCheck("R2 enable again", 5'h10, 16'h0105);
    drive(1'b0, 5'h10, 16'h0, 2'b00, 2'b01, 2'b00);
    readCheck("R6 detach", 5'h10, 16'h010A);
    drive(1'b0, 5'h10, 16'h0, 2'b00, 2'b01, 2'b00);
    readCheck("R6 detach idle", 5'h10, 16'h010A);

    // R4 reset write on disconnected port
    drive(1'b1, 5'h10, 16'h0200, 2'b00, 2'b00, 2'b00);
    check("R4 no pulse disconnected", {14'd0, busResetReq}, 16'h0000);
    readCheck("R4 reset bit stored", 5'h10, 16'h030A);
    drive(1'b1, 5'h10, 16'h000A, 2'b00, 2'b00, 2'b00);
    readCheck("R3 clear both changes", 5'h10, 16'h0100);

    // R9 write clearing change flag with attach in the same cycle
    drive(1'b1, 5'h10, 16'h0002, 2'b01, 2'b00, 2'b00);
    readCheck("R9 write plus attach", 5'h10, 16'h0003);

    // R5 attach on connected and enabled port
    drive(1'b1, 5'h10, 16'h0004, 2'b00, 2'b00, 2'b00);
    readCheck("R2 enable before reattach", 5'h10, 16'h0007);
    drive(1'b0, 5'h10, 16'h0, 2'b01, 2'b00, 2'b01);
    readCheck("R5 reattach enabled", 5'h10, 16'h010B);

    // R9 attach and detach together
    drive(1'b0, 5'h10, 16'h0, 2'b01, 2'b01, 2'b00);
    readCheck("R9 attach beats detach", 5'h10, 16'h000B);

    // R10 port1 untouched throughout
    readCheck("R10 port1 final", 5'h12, m1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule